// File: doc/BRIEF.md
# Peripheral Request to Channel Router

This block sits between a set of peripheral request lines and the channel engines of a DMA controller. Each of the 75 request lines has a small map register. The register names one of up to 32 channels and carries a flag that says whether the map is in use. While the flag is set, the live request level passes straight through to the request output of the named channel. Any number of requests may point at one channel; that channel's output is their OR.

Software programs the maps over a simple word-wide register bus. The maps sit in two separate address windows. Requests 0 to 63 occupy a dense window of 64 words. Requests 64 to 74 occupy a second window of 11 words much higher in the map. Reads are combinational. Writes take effect on the next clock edge. Every address outside the two windows reads as zero and ignores writes, and this includes three request-status words.

Top module: `req_router`

## Requirements
- R1: After reset every map reads as zero (not valid), and every channel output stays low for any request pattern.
- R2: A write to byte address 0x100 + 4*k (k from 0 to 63) updates the map of request k. Only write-data bits [4:0] (channel number) and bit 7 (valid flag) are stored. A read of that address returns the same two fields in the same positions, with zeros in every other bit.
- R3: A write to byte address 0x1100 + 4*j (j from 0 to 10) updates the map of request 64 + j. Read-back follows the same field layout as R2.
- R4: Channel output c is high exactly when at least one request input is high whose map is valid and names channel c. This path is combinational, with no register between the request input and the channel output.
- R5: A request whose map has the valid flag clear drives no channel output, whatever channel number it holds.
- R6: Reads of byte addresses 0xE0, 0xE4 and 0xE8 return zero, and writes to them change no map.
- R7: Addresses that are not word aligned, or that fall outside both map windows (for example 0x0FC, 0x200, 0x10FC and 0x112C), read as zero, and writes to them change no map.
- R8: When several valid requests name the same channel, that channel's output is their OR.
- R9: A map write changes the routing from the clock edge on which it is taken. Before that edge, the old map still routes. With no write, the maps hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the register bus |
| reg_addr | input | 13 | Byte address for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| req_in | input | 75 | Live peripheral request levels |
| chan_req | output | 32 | Request level presented to each channel |

## Verification
On every cycle, the assertions check several properties. With no request input high, no channel output may be high. The number of active channel outputs can never exceed the number of active requests. Read data never shows bits outside the two map fields. The status words read zero. The stored maps hold still when there is no write, and also when a write targets a status word. The exact channel each request reaches, read-back through both windows, the OR of shared channels, and the cycle in which a new map starts to route can only be shown by the bench. It checks these against its own model of the map table, using random and directed writes and request patterns.

// File: rtl/req_router_pkg.sv
package req_router_pkg;
    localparam int RR_DATA_W    = 32;
    localparam int RR_VALID_POS = 7;
    localparam int RR_LO_BASE   = 'h100;
    localparam int RR_HI_BASE   = 'h1100;
    localparam int RR_LO_COUNT  = 64;
endpackage

// File: rtl/req_router_decode.sv
module req_router_decode #(
    parameter int ADDR_W   = 13,
    parameter int N_REQ    = 75,
    parameter int LO_BASE  = 'h100,
    parameter int HI_BASE  = 'h1100,
    parameter int LO_COUNT = 64
) (
    input  logic [ADDR_W-1:0]          addr,
    output logic                       hit,
    output logic [$clog2(N_REQ)-1:0]   idx
);
    localparam int IDX_W    = $clog2(N_REQ);
    localparam int HI_COUNT = N_REQ - LO_COUNT;
    localparam logic [ADDR_W-1:0] LO_A   = ADDR_W'(LO_BASE);
    localparam logic [ADDR_W-1:0] LO_END = ADDR_W'(LO_BASE + 4 * LO_COUNT);
    localparam logic [ADDR_W-1:0] HI_A   = ADDR_W'(HI_BASE);
    localparam logic [ADDR_W-1:0] HI_END = ADDR_W'(HI_BASE + 4 * HI_COUNT);

    logic              aligned;
    logic              lo_hit;
    logic              hi_hit;
    logic [ADDR_W-1:0] lo_off;
    logic [ADDR_W-1:0] hi_off;

    always_comb begin
        aligned = (addr[1:0] == 2'b00);
        lo_hit  = aligned && (addr >= LO_A) && (addr < LO_END);
        hi_hit  = aligned && (addr >= HI_A) && (addr < HI_END);
        lo_off  = addr - LO_A;
        hi_off  = addr - HI_A;
        hit     = lo_hit || hi_hit;
        if (hi_hit) begin
            idx = IDX_W'(LO_COUNT) + hi_off[IDX_W+1:2];
        end else if (lo_hit) begin
            idx = lo_off[IDX_W+1:2];
        end else begin
            idx = '0;
        end
    end
endmodule

// File: rtl/req_router_maps.sv
module req_router_maps #(
    parameter int N_REQ = 75,
    parameter int CH_W  = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [$clog2(N_REQ)-1:0]  wr_idx,
    input  logic                      wr_valid,
    input  logic [CH_W-1:0]           wr_chan,
    output logic [N_REQ-1:0]          valid_q,
    output logic [N_REQ*CH_W-1:0]     chan_q
);
    typedef struct packed {
        logic [N_REQ-1:0]      valid;
        logic [N_REQ*CH_W-1:0] chan;
    } state_t;

    state_t state_d;
    state_t state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            state_d.valid[wr_idx]               = wr_valid;
            state_d.chan[wr_idx*CH_W +: CH_W]   = wr_chan;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign valid_q = state_q.valid;
    assign chan_q  = state_q.chan;
endmodule

// File: rtl/req_router_xbar.sv
module req_router_xbar #(
    parameter int N_REQ  = 75,
    parameter int N_CHAN = 32,
    parameter int CH_W   = 5
) (
    input  logic [N_REQ-1:0]      req_in,
    input  logic [N_REQ-1:0]      valid,
    input  logic [N_REQ*CH_W-1:0] chan,
    output logic [N_CHAN-1:0]     chan_req
);
    logic [N_REQ-1:0] live;

    assign live = req_in & valid;

    for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
        always_comb begin
            chan_req[c] = 1'b0;
            for (int r = 0; r < N_REQ; r++) begin
                if (live[r] && (chan[r*CH_W +: CH_W] == CH_W'(c))) begin
                    chan_req[c] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/req_router.sv
module req_router
    import req_router_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int N_REQ  = 75,
    parameter int N_CHAN = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [RR_DATA_W-1:0]  reg_wdata,
    output logic [RR_DATA_W-1:0]  reg_rdata,
    input  logic [N_REQ-1:0]      req_in,
    output logic [N_CHAN-1:0]     chan_req
);
    localparam int CH_W  = $clog2(N_CHAN);
    localparam int IDX_W = $clog2(N_REQ);

    logic                  hit;
    logic [IDX_W-1:0]      idx;
    logic [N_REQ-1:0]      valid_q;
    logic [N_REQ*CH_W-1:0] chan_q;
    logic [N_REQ*(CH_W+1)-1:0] map_flat;

    req_router_decode #(
        .ADDR_W(ADDR_W), .N_REQ(N_REQ), .LO_BASE(RR_LO_BASE),
        .HI_BASE(RR_HI_BASE), .LO_COUNT(RR_LO_COUNT)
    ) u_dec (
        .addr(reg_addr), .hit(hit), .idx(idx)
    );

    req_router_maps #(.N_REQ(N_REQ), .CH_W(CH_W)) u_maps (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr && hit), .wr_idx(idx),
        .wr_valid(reg_wdata[RR_VALID_POS]), .wr_chan(reg_wdata[CH_W-1:0]),
        .valid_q(valid_q), .chan_q(chan_q)
    );

    req_router_xbar #(.N_REQ(N_REQ), .N_CHAN(N_CHAN), .CH_W(CH_W)) u_xbar (
        .req_in(req_in), .valid(valid_q), .chan(chan_q), .chan_req(chan_req)
    );

    always_comb begin
        reg_rdata = '0;
        if (hit) begin
            reg_rdata[RR_VALID_POS] = valid_q[idx];
            reg_rdata[CH_W-1:0]     = chan_q[idx*CH_W +: CH_W];
        end
    end

    assign map_flat = {valid_q, chan_q};
endmodule

// File: rtl/req_router_chk.sv
module req_router_chk #(
    parameter int ADDR_W = 13,
    parameter int N_REQ  = 75,
    parameter int N_CHAN = 32,
    parameter int MAP_W  = 450
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_rdata,
    input logic [N_REQ-1:0]  req_in,
    input logic [N_CHAN-1:0] chan_req,
    input logic [MAP_W-1:0]  maps
);
    logic status_addr;
    logic gap_addr;
    assign status_addr = (reg_addr == ADDR_W'('hE0)) || (reg_addr == ADDR_W'('hE4)) ||
                         (reg_addr == ADDR_W'('hE8));
    assign gap_addr    = (reg_addr >= ADDR_W'('h200)) && (reg_addr < ADDR_W'('h1100));

    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_in == '0) |-> (chan_req == '0));

    p_fanout_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(chan_req) <= $countones(req_in));

    p_rdata_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[31:8] == '0) && (reg_rdata[6:5] == '0));

    p_status_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        status_addr |-> (reg_rdata == '0));

    p_status_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && status_addr) |=> $stable(maps));

    p_gap_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        gap_addr |-> (reg_rdata == '0));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(maps));
endmodule

bind req_router req_router_chk #(
    .ADDR_W(ADDR_W), .N_REQ(N_REQ), .N_CHAN(N_CHAN), .MAP_W(N_REQ*($clog2(N_CHAN)+1))
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_rdata(reg_rdata), .req_in(req_in), .chan_req(chan_req), .maps(map_flat)
);

// File: tb/req_router_test.sv
module req_router_test;
    localparam int NR = 75;
    localparam int NC = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [12:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NR-1:0] req_in = '0;
    logic [NC-1:0] chan_req;

    int vectors = 0;
    int errors = 0;
    logic [7:0] model [NR];

    always #2 clk = ~clk;

    req_router uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_in(req_in), .chan_req(chan_req)
    );

    function automatic logic [12:0] addr_of(int k);
        if (k < 64) return 13'(32'h100 + 4 * k);
        return 13'(32'h1100 + 4 * (k - 64));
    endfunction

    function automatic int index_of(logic [12:0] a);
        if (a[1:0] != 2'b00) return -1;
        if (a >= 13'h100 && a <= 13'h1FC) return int'((a - 13'h100) >> 2);
        if (a >= 13'h1100 && a <= 13'h1128) return 64 + int'((a - 13'h1100) >> 2);
        return -1;
    endfunction

    function automatic logic [NC-1:0] route_of(logic [NR-1:0] r);
        logic [NC-1:0] o = '0;
        for (int k = 0; k < NR; k++)
            if (r[k] && model[k][7]) o[model[k][4:0]] = 1'b1;
        return o;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [12:0] a, logic [31:0] d);
        int k;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        k = index_of(a);
        if (k >= 0) model[k] = {d[7], 2'b00, d[4:0]};
    endtask

    task automatic read_check(string tag, logic [12:0] a);
        int k;
        @(negedge clk);
        reg_addr = a;
        #1;
        k = index_of(a);
        check(tag, reg_rdata, (k >= 0) ? {24'h0, model[k]} : 32'h0);
    endtask

    task automatic route_check(string tag, logic [NR-1:0] r);
        @(negedge clk);
        req_in = r;
        #1;
        check(tag, 32'(chan_req), 32'(route_of(r)));
    endtask

    task automatic read_all(string tag);
        for (int k = 0; k < NR; k++) read_check(tag, addr_of(k));
    endtask

    function automatic logic [NR-1:0] rand_req();
        return {$urandom(), $urandom(), $urandom()};
    endfunction

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [NR-1:0] r;
        logic [12:0] bad [8];
        void'($urandom(32'd4242));
        for (int k = 0; k < NR; k++) model[k] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        read_all("R1 reset map");
        route_check("R1 reset route", '1);

        // R2 / R3: field masking in both windows
        bus_write(addr_of(0), 32'hFFFF_FF85);
        read_check("R2 low mask", addr_of(0));
        bus_write(addr_of(63), 32'h0000_009F);
        read_check("R2 low top", addr_of(63));
        bus_write(addr_of(64), 32'hFFFF_FF9E);
        read_check("R3 high first", addr_of(64));
        bus_write(addr_of(74), 32'h0000_0081);
        read_check("R3 high last", addr_of(74));

        // R5: invalid map routes nothing
        bus_write(addr_of(10), 32'h0000_0003);
        r = '0; r[10] = 1'b1;
        route_check("R5 invalid", r);
        check("R5 invalid out", 32'(chan_req), 32'h0);

        // R8: two requests share channel 30
        bus_write(addr_of(5), 32'h0000_009E);
        r = '0; r[5] = 1'b1; r[64] = 1'b1;
        route_check("R8 shared both", r);
        r = '0; r[64] = 1'b1;
        route_check("R8 shared one", r);
        check("R8 shared ch30", 32'(chan_req[30]), 32'h1);

        // R9: new map routes only after the edge
        r = '0; r[20] = 1'b1;
        req_in = r;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = addr_of(20); reg_wdata = 32'h0000_0087;
        #1;
        check("R9 before edge", 32'(chan_req), 32'h0);
        @(negedge clk);
        reg_wr = 1'b0;
        model[20] = 8'h87;
        #1;
        check("R9 after edge", 32'(chan_req), 32'h0000_0080);

        // R6 / R7: status words, gaps, misaligned
        bad[0] = 13'h0E0; bad[1] = 13'h0E4; bad[2] = 13'h0E8; bad[3] = 13'h0FC;
        bad[4] = 13'h200; bad[5] = 13'h10FC; bad[6] = 13'h112C; bad[7] = 13'h101;
        for (int i = 0; i < 8; i++) begin
            bus_write(bad[i], 32'hFFFF_FFFF);
            read_check(i < 3 ? "R6 status zero" : "R7 outside zero", bad[i]);
        end
        read_all("R7 maps untouched");

        // R4: random maps and request patterns
        for (int it = 0; it < 400; it++) begin
            int k;
            k = int'($urandom_range(NR - 1));
            case ($urandom_range(3))
                0: bus_write(addr_of(k), $urandom());
                1: read_check(k < 64 ? "R2 rand read" : "R3 rand read", addr_of(k));
                2: bus_write(13'($urandom()), $urandom());
                default: route_check("R4 rand route", rand_req());
            endcase
        end
        for (int it = 0; it < 40; it++) route_check("R4 rand route", rand_req());
        read_all("R9 final hold");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule